// File: doc/BRIEF.md
# PLL Frequency Programming Sequencer

This block moves a frequency synthesizer to a new output frequency with frequency modulation kept off. A one-cycle `start` pulse hands it a target pre-divider, multiplier and output divider. It first checks that the phase-detector input frequency is legal for the reference frequency, which is given as a parameter in kHz. It then sends an ordered series of whole control-register images through a valid/ready write port. It keeps a shadow copy of the last image written, so each write changes only the fields that step needs.

The sequence takes the synthesizer to a lower intermediate frequency first, to limit the surge in supply current. It does this by setting the output divider one above the target. It then waits for the lock input, with a programmable timeout. Only after lock does it apply the final output divider and enable the loss-of-lock interrupt again.

States and transitions: IDLE goes to CHECK on `start`. CHECK goes to WR_SAFE when the request is legal and to FAIL when it is not. WR_SAFE, WR_RAMP, WR_FINAL and WR_IRQ each wait for `wr_ready` and then go on to the next step in that order; WR_RAMP is followed by WAIT_LOCK. WAIT_LOCK goes to WR_FINAL when lock is seen and to FAIL when the timer expires. WR_IRQ goes to FINISH, and FINISH and FAIL both return to IDLE.

Top module: `pll_freq_seq`

## Requirements
- R1: A request is rejected when the pre-divider P fails `P*4000 <= REF_KHZ <= P*20000`. A P of 0 therefore always fails. A rejected request makes no register write, raises `error`, and does not pulse `done`.
- R2: A request whose target output divider is all ones is rejected in the same way, because target plus one cannot be encoded.
- R3: The control word layout is: bit 16 loss-of-lock interrupt enable, bit 15 loss-of-lock reset enable, bits 14:13 modulation depth, bits 12:10 pre-divider, bits 9:3 multiplier, bits 2:0 output divider. The first write equals the shadow with modulation depth 00 and reset enable 0, and all other fields are unchanged. Every write has depth 00 and reset enable 0. The shadow after reset is 1,1,10,1,8,1.
- R4: The second write equals the first with interrupt enable 0, pre-divider and multiplier at their targets, and output divider at target plus one.
- R5: The final-divider write is not issued until lock has been seen after the second write.
- R6: After lock the third write changes only the output divider, to the target. The fourth write changes only the interrupt enable, to 1. A successful run makes exactly four writes.
- R7: If lock is not seen within `lock_tmo` cycles of waiting, the sequencer raises `error` and stops after two writes.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` stays unchanged.
- R9: A `start` pulse that arrives while `busy` is high is ignored.
- R10: `done` pulses for exactly one cycle after a successful run. `error` stays high until the next accepted `start` clears it.
- R11: After reset, `busy`, `wr_valid`, `done` and `error` are low. `busy` is high from the cycle after an accepted `start` until the return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| tgt_pdiv | input | 3 | Target pre-divider |
| tgt_mult | input | 7 | Target multiplier |
| tgt_odiv | input | 3 | Target output divider |
| lock_tmo | input | TMO_W (8) | Lock wait limit in cycles |
| lock | input | 1 | Synthesizer lock status |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_data | output | 17 | Control register image |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Sticky failure flag |

## Verification
A wrong state or a corrupted shadow shows up at the write port within one handshake. The write count, the order of the writes or a field value then differs from the model the bench builds from the requirements. A lock wait that is skipped or too short shows up as a final-divider write arriving fewer cycles after the ramp write than the lock delay allows. A sequencer that fails to return to IDLE shows up as `busy` still high after its run window, or as `done` or `error` in the wrong state on the cycle after the run.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int PDIV_W = 3;
    localparam int MULT_W = 7;
    localparam int ODIV_W = 3;

    typedef struct packed {
        logic              irq_en;
        logic              lol_rst_en;
        logic [1:0]        mod_depth;
        logic [PDIV_W-1:0] pdiv;
        logic [MULT_W-1:0] mult;
        logic [ODIV_W-1:0] odiv;
    } synth_ctl_t;

    localparam int CTL_W = $bits(synth_ctl_t);

    localparam synth_ctl_t CTL_RESET = '{
        irq_en:     1'b1,
        lol_rst_en: 1'b1,
        mod_depth:  2'b10,
        pdiv:       PDIV_W'(1),
        mult:       MULT_W'(8),
        odiv:       ODIV_W'(1)
    };

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WR_SAFE,
        ST_WR_RAMP,
        ST_WAIT_LOCK,
        ST_WR_FINAL,
        ST_WR_IRQ,
        ST_FINISH,
        ST_FAIL
    } seq_state_t;

endpackage

// File: rtl/pll_seq_range_chk.sv
module pll_seq_range_chk #(
    parameter int REF_KHZ = 24000,
    parameter int PDIV_W  = 3,
    parameter int ODIV_W  = 3
) (
    input  logic [PDIV_W-1:0] pdiv,
    input  logic [ODIV_W-1:0] odiv,
    output logic              req_ok
);
    localparam logic [31:0] PFD_MIN_KHZ = 32'd4000;
    localparam logic [31:0] PFD_MAX_KHZ = 32'd20000;
    localparam logic [31:0] REF_K       = 32'(REF_KHZ);

    logic [31:0] lo_bound;
    logic [31:0] hi_bound;
    logic        pfd_ok;
    logic        odiv_ok;

    // Multiply instead of dividing the reference by the pre-divider.
    always_comb begin
        lo_bound = 32'(pdiv) * PFD_MIN_KHZ;
        hi_bound = 32'(pdiv) * PFD_MAX_KHZ;
        pfd_ok   = (lo_bound <= REF_K) && (REF_K <= hi_bound);
        odiv_ok  = (odiv != '1);
        req_ok   = pfd_ok && odiv_ok;
    end
endmodule

// File: rtl/pll_seq_lock_timer.sv
module pll_seq_lock_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    always_comb begin
        expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
    end
endmodule

// File: rtl/pll_seq_word_build.sv
module pll_seq_word_build
    import pll_seq_pkg::*;
(
    input  seq_state_t        state,
    input  synth_ctl_t        shadow,
    input  logic [PDIV_W-1:0] pdiv,
    input  logic [MULT_W-1:0] mult,
    input  logic [ODIV_W-1:0] odiv,
    output synth_ctl_t        word
);
    always_comb begin
        word = shadow;
        unique case (state)
            ST_WR_SAFE: begin
                word.mod_depth  = 2'b00;
                word.lol_rst_en = 1'b0;
            end
            ST_WR_RAMP: begin
                word.mod_depth  = 2'b00;
                word.lol_rst_en = 1'b0;
                word.irq_en     = 1'b0;
                word.pdiv       = pdiv;
                word.mult       = mult;
                word.odiv       = odiv + 1'b1;
            end
            ST_WR_FINAL: word.odiv   = odiv;
            ST_WR_IRQ:   word.irq_en = 1'b1;
            default:     word = shadow;
        endcase
    end
endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ = 24000,
    parameter int TMO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PDIV_W-1:0] tgt_pdiv,
    input  logic [MULT_W-1:0] tgt_mult,
    input  logic [ODIV_W-1:0] tgt_odiv,
    input  logic [TMO_W-1:0]  lock_tmo,
    input  logic              lock,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [CTL_W-1:0]  wr_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    seq_state_t        state, nstate;
    synth_ctl_t        shadow, word;
    logic [PDIV_W-1:0] r_pdiv;
    logic [MULT_W-1:0] r_mult;
    logic [ODIV_W-1:0] r_odiv;
    logic [TMO_W-1:0]  r_tmo;
    logic              req_ok;
    logic              tmo_hit;
    logic              accept;
    logic              wr_fire;

    assign accept  = (state == ST_IDLE) && start;
    assign wr_fire = wr_valid && wr_ready;

    pll_seq_range_chk #(
        .REF_KHZ (REF_KHZ),
        .PDIV_W  (PDIV_W),
        .ODIV_W  (ODIV_W)
    ) u_range (
        .pdiv   (r_pdiv),
        .odiv   (r_odiv),
        .req_ok (req_ok)
    );

    pll_seq_lock_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT_LOCK),
        .limit   (r_tmo),
        .expired (tmo_hit)
    );

    pll_seq_word_build u_word (
        .state  (state),
        .shadow (shadow),
        .pdiv   (r_pdiv),
        .mult   (r_mult),
        .odiv   (r_odiv),
        .word   (word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:      if (start) nstate = ST_CHECK;
            ST_CHECK:     nstate = req_ok ? ST_WR_SAFE : ST_FAIL;
            ST_WR_SAFE:   if (wr_ready) nstate = ST_WR_RAMP;
            ST_WR_RAMP:   if (wr_ready) nstate = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (lock)         nstate = ST_WR_FINAL;
                else if (tmo_hit) nstate = ST_FAIL;
            end
            ST_WR_FINAL:  if (wr_ready) nstate = ST_WR_IRQ;
            ST_WR_IRQ:    if (wr_ready) nstate = ST_FINISH;
            ST_FINISH:    nstate = ST_IDLE;
            ST_FAIL:      nstate = ST_IDLE;
            default:      nstate = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        wr_valid = 1'b0;
        unique case (state)
            ST_WR_SAFE, ST_WR_RAMP, ST_WR_FINAL, ST_WR_IRQ: wr_valid = 1'b1;
            default: wr_valid = 1'b0;
        endcase
        wr_data = word;
    end

    // Request capture, shadow image and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_pdiv <= '0;
            r_mult <= '0;
            r_odiv <= '0;
            r_tmo  <= '0;
            shadow <= CTL_RESET;
            error  <= 1'b0;
        end else begin
            if (accept) begin
                r_pdiv <= tgt_pdiv;
                r_mult <= tgt_mult;
                r_odiv <= tgt_odiv;
                r_tmo  <= lock_tmo;
                error  <= 1'b0;
            end else if (state == ST_FAIL) begin
                error  <= 1'b1;
            end
            if (wr_fire) shadow <= word;
        end
    end
endmodule

// File: rtl/pll_freq_seq_chk.sv
module pll_freq_seq_chk #(
    parameter int W = 17
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_valid,
    input logic         wr_ready,
    input logic [W-1:0] wr_data,
    input logic         busy,
    input logic         done,
    input logic         error
);
    // R8
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

    // R3
    no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[W-3 -: 2] == 2'b00) && !wr_data[W-2]);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid && !done);

    // R11
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    err_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !done);
endmodule

bind pll_freq_seq pll_freq_seq_chk #(.W(pll_seq_pkg::CTL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/sim_pll_freq_seq.sv
module sim_pll_freq_seq;
    localparam int CW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    tgt_pdiv = '0;
    logic [6:0]    tgt_mult = '0;
    logic [2:0]    tgt_odiv = '0;
    logic [7:0]    lock_tmo = '0;
    logic          lock = 1'b0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [CW-1:0] wr_data;
    logic          busy, done, error;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_freq_seq #(.REF_KHZ(24000), .TMO_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_pdiv(tgt_pdiv), .tgt_mult(tgt_mult), .tgt_odiv(tgt_odiv),
        .lock_tmo(lock_tmo), .lock(lock),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .busy(busy), .done(done), .error(error)
    );

    // outcome: 0 success, 1 rejected, 2 lock timeout; delay 255 = never locks
    localparam logic [30:0] VECS [8] = '{
        {3'd2, 7'd40, 3'd2, 8'd3,   8'd20, 2'd0},
        {3'd1, 7'd40, 3'd2, 8'd0,   8'd20, 2'd1},
        {3'd6, 7'd50, 3'd1, 8'd5,   8'd30, 2'd0},
        {3'd7, 7'd30, 3'd2, 8'd0,   8'd20, 2'd1},
        {3'd3, 7'd60, 3'd7, 8'd0,   8'd20, 2'd1},
        {3'd4, 7'd20, 3'd0, 8'd255, 8'd4,  2'd2},
        {3'd5, 7'd33, 3'd3, 8'd1,   8'd10, 2'd0},
        {3'd0, 7'd10, 3'd1, 8'd0,   8'd20, 2'd1}
    };

    logic [CW-1:0] shadow_m = {1'b1, 1'b1, 2'b10, 3'd1, 7'd8, 3'd1};
    logic [CW-1:0] log_w [4];
    int            nwr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] set_fields(input logic [CW-1:0] w,
        input logic irq, input logic [2:0] p, input logic [6:0] m, input logic [2:0] o);
        return {irq, w[15], w[14:13], p, m, o};
    endfunction

    task automatic run_req(input logic [2:0] p, input logic [6:0] m, input logic [2:0] o,
                           input int dly, input logic [7:0] tmo, input int outcome,
                           input int intrude, input string tag);
        logic [CW-1:0] e0, e1, e2, e3;
        int dn = 0, lcnt = -1, c1 = 0, c2 = 0, it = 0;
        nwr = 0;
        lock = 1'b0;
        @(negedge clk);
        start = 1'b1; tgt_pdiv = p; tgt_mult = m; tgt_odiv = o; lock_tmo = tmo;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R11 busy after start"}, busy, 1);
        chk(error == 1'b0, {tag, " R10 error cleared by start"}, error, 0);
        while (busy && it < 600) begin
            it++;
            if (intrude != 0 && it == intrude) begin
                start = 1'b1; tgt_pdiv = 3'd3; tgt_mult = 7'd99; tgt_odiv = 3'd5;
            end else begin
                start = 1'b0;
            end
            if (lcnt == 0) lock = 1'b1;
            else if (lcnt > 0) lcnt--;
            wr_ready = (cyc % 3) != 2;
            if (done) dn++;
            if (wr_valid && wr_ready) begin
                if (nwr < 4) log_w[nwr] = wr_data;
                if (nwr == 1) begin c1 = it; lcnt = (dly == 255) ? -1 : dly; if (lcnt == 0) lock = 1'b1; end
                if (nwr == 2) c2 = it;
                nwr++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (done) dn++;
        chk(!busy, {tag, " R11 returns idle"}, busy, 0);
        e0 = {shadow_m[16], 1'b0, 2'b00, shadow_m[12:0]};
        e1 = set_fields(e0, 1'b0, p, m, o + 3'd1);
        e2 = set_fields(e1, 1'b0, p, m, o);
        e3 = set_fields(e2, 1'b1, p, m, o);
        if (outcome == 1) begin
            chk(nwr == 0, {tag, " R1 R2 no writes on reject"}, nwr, 0);
            chk(error, {tag, " R1 R2 error on reject"}, error, 1);
            chk(dn == 0, {tag, " R1 no done on reject"}, dn, 0);
        end else if (outcome == 2) begin
            chk(nwr == 2, {tag, " R7 two writes on timeout"}, nwr, 2);
            chk(error, {tag, " R7 error on timeout"}, error, 1);
            chk(dn == 0, {tag, " R7 no done on timeout"}, dn, 0);
            chk(log_w[0] == e0, {tag, " R3 first write"}, int'(log_w[0]), int'(e0));
            chk(log_w[1] == e1, {tag, " R4 ramp write"}, int'(log_w[1]), int'(e1));
            shadow_m = e1;
        end else begin
            chk(nwr == 4, {tag, " R6 four writes"}, nwr, 4);
            chk(log_w[0] == e0, {tag, " R3 first write"}, int'(log_w[0]), int'(e0));
            chk(log_w[1] == e1, {tag, " R4 ramp write"}, int'(log_w[1]), int'(e1));
            chk(log_w[2] == e2, {tag, " R6 final divider write"}, int'(log_w[2]), int'(e2));
            chk(log_w[3] == e3, {tag, " R6 interrupt re-enable write"}, int'(log_w[3]), int'(e3));
            chk(c2 - c1 > dly, {tag, " R5 final write waits for lock"}, c2 - c1, dly + 1);
            chk(dn == 1, {tag, " R10 single done pulse"}, dn, 1);
            chk(!error, {tag, " R10 no error on success"}, error, 0);
            shadow_m = e3;
        end
        lock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_valid && !done && !error, "R11 reset state",
            {busy, wr_valid, done, error}, 0);

        for (int i = 0; i < 8; i++) begin
            run_req(VECS[i][30:28], VECS[i][27:21], VECS[i][20:18],
                    int'(VECS[i][17:10]), VECS[i][9:2], int'(VECS[i][1:0]), 0,
                    $sformatf("vec%0d", i));
        end

        // R10: error stays set while idle after a rejection
        run_req(3'd1, 7'd12, 3'd1, 0, 8'd20, 1, 0, "sticky");
        repeat (6) @(negedge clk);
        chk(error == 1'b1, "R10 error sticky while idle", error, 1);

        // R9: a second start during the run is ignored
        run_req(3'd2, 7'd44, 3'd4, 6, 8'd40, 0, 3, "intrude");
        repeat (4) @(negedge clk);
        chk(!busy, "R9 no second run after intruding start", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule